// File: doc/BRIEF.md
# Multiplexed Readout Demodulator and Discriminator

This block turns one digitized return stream, which carries the responses of several frequency-multiplexed readout resonators, into one state bit per channel. A single sample bus fans out to `NCH` channel slices. Each slice mixes the sample with its own cosine and sine local oscillator to give I and Q, and weights both with a per-channel envelope held in a small weight memory. The weighted I and Q are summed over an integration window that all slices share.

When the window closes, each slice forms a weighted projection of its two sums and compares it with its own signed threshold. The bits of all channels then appear together on one vector with a single-cycle strobe. A controller reacts to a rising edge on the start input by latching the window length. It then takes one sample on every clock until the window ends, and it ignores new requests while a window is still in progress. Frequency words, projection weights and thresholds are plain inputs and must be held steady during a window. Envelope weights are loaded through a narrow write port.

Top module: `mux_readout_core`

## Requirements
- R1: Each channel has a 32-bit phase accumulator that is cleared when a window is accepted. Sample k of the window (k = 0, 1, ...) is mixed at phase k*F mod 2^32, where F is that channel's frequency word. The oscillator octant is phase bits [31:29]. For octants 0..7 the cosine value is 64, 45, 0, -45, -64, -45, 0, 45, and the sine value is the cosine value of the octant two steps lower (mod 8).
- R2: For sample k, channel c adds sample*cos*W[c][k] to a signed 40-bit I sum and sample*sin*W[c][k] to a signed 40-bit Q sum. Both sums are cleared when the window is accepted. W[c][a] is the signed weight written at address a of channel c.
- R3: At the end of a window, bit c of `results` is 1 only when PI[c]*sumI + PQ[c]*sumQ is strictly greater than the signed threshold of channel c; equality gives 0.
- R4: If the window is accepted at clock edge E0 with length L, `results_valid` stays 0 until E0+L and is 1 after edge E0+L+1, together with the new results. After reset, `results_valid` and `results` are 0.
- R5: `results_valid` is high for exactly one cycle per window, and `results` keeps its value until the next window delivers.
- R6: A start request that arrives while a window is running, or in its final cycle, is ignored: it restarts nothing, reloads no length and causes no extra strobe.
- R7: A request is a rising edge of `win_start`. A start that is held high from reset into operation is not a request. A request with a length of 0 or above `MAX_LEN` is ignored.
- R8: A weight write (`wt_we` with channel `wt_ch` and address `wt_addr`) affects only that channel and address, and is used by every later window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_start | input | 1 | Window request, rising edge |
| win_len | input | LEN_W (7) | Window length in samples, latched on accept |
| sample_in | input | SAMP_W (12) | Signed input sample, one per clock while a window runs |
| ftw_flat | input | NCH*32 | Per-channel frequency words, channel c at bits [32c+31:32c] |
| wt_we | input | 1 | Envelope weight write enable |
| wt_ch | input | CH_W (2) | Channel selected for the weight write |
| wt_addr | input | ADDR_W (6) | Weight address (sample index) |
| wt_data | input | WT_W (12) | Signed weight value |
| proj_i_flat | input | NCH*WT_W | Per-channel signed I projection weights |
| proj_q_flat | input | NCH*WT_W | Per-channel signed Q projection weights |
| thr_flat | input | NCH*PROJ_W | Per-channel signed thresholds (PROJ_W = 53) |
| results_valid | output | 1 | Single-cycle strobe for a new result vector |
| results | output | NCH | Per-channel state decisions |

## Verification
Taking E0 as the edge that accepts a window of length L, the bench drives sample k in the half cycle before edge E0+k+1. After the last sample it looks at the outputs at the falling edge after E0+L, where the strobe must still be low. At the falling edge after E0+L+1 it expects the strobe and the full result vector. For several idle cycles after that, it expects the strobe to be low and the vector unchanged. Requests that must be ignored, such as ones made mid-window, in the final cycle, with an illegal length or held through reset, are checked by counting enough later cycles to confirm that no extra strobe appears and that the window in progress still delivers on schedule.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  localparam int LO_W = 8;
  typedef logic signed [LO_W-1:0] lo_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} win_state_e;

  // Octant cosine: 64 * cos(oct * 45 deg), rounded.
  function automatic lo_t lo_cos(input logic [2:0] oct);
    case (oct)
      3'd0:    lo_cos = 8'sd64;
      3'd1:    lo_cos = 8'sd45;
      3'd2:    lo_cos = 8'sd0;
      3'd3:    lo_cos = -8'sd45;
      3'd4:    lo_cos = -8'sd64;
      3'd5:    lo_cos = -8'sd45;
      3'd6:    lo_cos = 8'sd0;
      default: lo_cos = 8'sd45;
    endcase
  endfunction

  // sin(x) = cos(x - 90 deg), two octants back.
  function automatic lo_t lo_sin(input logic [2:0] oct);
    return lo_cos(oct - 3'd2);
  endfunction

endpackage

// File: rtl/rdo_window_ctrl.sv
module rdo_window_ctrl #(
  parameter int MAX_LEN = 64,
  parameter int ADDR_W  = 6,
  parameter int LEN_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_start,
  input  logic [LEN_W-1:0]  win_len,
  output logic              accept,
  output logic              run,
  output logic              fin,
  output logic [ADDR_W-1:0] idx,
  output logic [LEN_W-1:0]  len_q
);
  import rdo_pkg::*;

  win_state_e state;
  logic       start_prev;
  logic       len_ok;
  logic       last;

  assign len_ok = (win_len != '0) && (win_len <= LEN_W'(MAX_LEN));
  assign accept = win_start && !start_prev && (state == ST_IDLE) && len_ok;
  assign run    = (state == ST_RUN);
  assign fin    = (state == ST_FIN);
  assign last   = run && ((LEN_W'(idx) + LEN_W'(1)) == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_prev <= 1'b1;
      state      <= ST_IDLE;
      idx        <= '0;
      len_q      <= '0;
    end else begin
      start_prev <= win_start;
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_RUN;
          idx   <= '0;
          len_q <= win_len;
        end
        ST_RUN: begin
          idx <= idx + ADDR_W'(1);
          if (last) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdo_channel.sv
module rdo_channel #(
  parameter int CH_IDX  = 0,
  parameter int CH_W    = 2,
  parameter int SAMP_W  = 12,
  parameter int WT_W    = 12,
  parameter int ACC_W   = 40,
  parameter int PROJ_W  = 53,
  parameter int PH_W    = 32,
  parameter int MAX_LEN = 64,
  parameter int ADDR_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     run,
  input  logic                     fin,
  input  logic [ADDR_W-1:0]        idx,
  input  logic signed [SAMP_W-1:0] sample_in,
  input  logic [PH_W-1:0]          ftw,
  input  logic                     wt_we,
  input  logic [CH_W-1:0]          wt_ch,
  input  logic [ADDR_W-1:0]        wt_addr,
  input  logic signed [WT_W-1:0]   wt_data,
  input  logic signed [WT_W-1:0]   proj_i,
  input  logic signed [WT_W-1:0]   proj_q,
  input  logic signed [PROJ_W-1:0] thr,
  output logic                     decision
);
  import rdo_pkg::*;

  localparam int MIX_W = SAMP_W + LO_W;

  logic signed [WT_W-1:0]   wt_mem [MAX_LEN];
  logic [PH_W-1:0]          phase_q;
  logic [2:0]               oct;
  lo_t                      lo_c, lo_s;
  logic signed [WT_W-1:0]   wt_cur;
  logic signed [MIX_W-1:0]  mix_i, mix_q;
  logic signed [ACC_W-1:0]  term_i, term_q;
  logic signed [ACC_W-1:0]  acc_i, acc_q;
  logic signed [PROJ_W-1:0] proj;

  // Envelope weight store, written through the shared narrow port.
  always_ff @(posedge clk) begin
    if (wt_we && (wt_ch == CH_W'(CH_IDX))) wt_mem[wt_addr] <= wt_data;
  end

  assign oct    = phase_q[PH_W-1 -: 3];
  assign lo_c   = lo_cos(oct);
  assign lo_s   = lo_sin(oct);
  assign wt_cur = wt_mem[idx];

  assign mix_i  = MIX_W'(sample_in) * MIX_W'(lo_c);
  assign mix_q  = MIX_W'(sample_in) * MIX_W'(lo_s);
  assign term_i = ACC_W'(mix_i) * ACC_W'(wt_cur);
  assign term_q = ACC_W'(mix_q) * ACC_W'(wt_cur);

  assign proj = PROJ_W'(proj_i) * PROJ_W'(acc_i) + PROJ_W'(proj_q) * PROJ_W'(acc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      acc_i    <= '0;
      acc_q    <= '0;
      decision <= 1'b0;
    end else begin
      if (accept) begin
        phase_q <= '0;
        acc_i   <= '0;
        acc_q   <= '0;
      end else if (run) begin
        phase_q <= phase_q + ftw;
        acc_i   <= acc_i + term_i;
        acc_q   <= acc_q + term_q;
      end
      if (fin) decision <= (proj > thr);
    end
  end
endmodule

// File: rtl/mux_readout_core.sv
module mux_readout_core #(
  parameter int NCH     = 4,
  parameter int SAMP_W  = 12,
  parameter int WT_W    = 12,
  parameter int ACC_W   = 40,
  parameter int PH_W    = 32,
  parameter int MAX_LEN = 64,
  localparam int ADDR_W = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PROJ_W = ACC_W + WT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     win_start,
  input  logic [LEN_W-1:0]         win_len,
  input  logic signed [SAMP_W-1:0] sample_in,
  input  logic [NCH*PH_W-1:0]      ftw_flat,
  input  logic                     wt_we,
  input  logic [CH_W-1:0]          wt_ch,
  input  logic [ADDR_W-1:0]        wt_addr,
  input  logic signed [WT_W-1:0]   wt_data,
  input  logic [NCH*WT_W-1:0]      proj_i_flat,
  input  logic [NCH*WT_W-1:0]      proj_q_flat,
  input  logic [NCH*PROJ_W-1:0]    thr_flat,
  output logic                     results_valid,
  output logic [NCH-1:0]           results
);

  // Named internal events, also observed by the bound checker.
  logic              win_accept;
  logic              win_run;
  logic              win_fin;
  logic [ADDR_W-1:0] win_idx;
  logic [LEN_W-1:0]  len_q;

  rdo_window_ctrl #(
    .MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_len(win_len),
    .accept(win_accept), .run(win_run), .fin(win_fin), .idx(win_idx), .len_q(len_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rdo_channel #(
      .CH_IDX(c), .CH_W(CH_W), .SAMP_W(SAMP_W), .WT_W(WT_W), .ACC_W(ACC_W),
      .PROJ_W(PROJ_W), .PH_W(PH_W), .MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W)
    ) i_ch (
      .clk(clk), .rst_n(rst_n),
      .accept(win_accept), .run(win_run), .fin(win_fin), .idx(win_idx),
      .sample_in(sample_in),
      .ftw(ftw_flat[c*PH_W +: PH_W]),
      .wt_we(wt_we), .wt_ch(wt_ch), .wt_addr(wt_addr), .wt_data(wt_data),
      .proj_i(proj_i_flat[c*WT_W +: WT_W]),
      .proj_q(proj_q_flat[c*WT_W +: WT_W]),
      .thr(thr_flat[c*PROJ_W +: PROJ_W]),
      .decision(results[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) results_valid <= 1'b0;
    else        results_valid <= win_fin;
  end
endmodule

// File: rtl/mux_readout_core_chk.sv
module mux_readout_core_chk #(
  parameter int NCH     = 4,
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] win_len,
  input logic             results_valid,
  input logic [NCH-1:0]   results,
  input logic             win_accept,
  input logic             win_run,
  input logic             win_fin,
  input logic [LEN_W-1:0] len_q
);

  a_r4_strobe_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
    win_fin |=> results_valid);

  a_r4_strobe_needs_fin: assert property (@(posedge clk) disable iff (!rst_n)
    results_valid |-> $past(win_fin));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    results_valid |=> !results_valid);

  a_r5_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !results_valid |-> $stable(results));

  a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (win_run || win_fin) |-> !win_accept);

  a_r6_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (win_run || win_fin) |=> $stable(len_q));

  a_r7_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    win_accept |-> (win_len != '0) && (win_len <= LEN_W'(MAX_LEN)));

endmodule

bind mux_readout_core mux_readout_core_chk #(
  .NCH(NCH), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .win_len(win_len),
  .results_valid(results_valid), .results(results),
  .win_accept(win_accept), .win_run(win_run), .win_fin(win_fin), .len_q(len_q)
);

// File: tb/test_mux_readout_core.sv
module test_mux_readout_core;
  localparam int CLK_P   = 10;
  localparam int NCH     = 4;
  localparam int SAMP_W  = 12;
  localparam int WT_W    = 12;
  localparam int ACC_W   = 40;
  localparam int MAX_LEN = 64;
  localparam int ADDR_W  = 6;
  localparam int LEN_W   = 7;
  localparam int CH_W    = 2;
  localparam int PROJ_W  = ACC_W + WT_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_start = 1'b1;
  logic [LEN_W-1:0] win_len = LEN_W'(3);
  logic signed [SAMP_W-1:0] sample_in = '0;
  logic [NCH*32-1:0] ftw_flat;
  logic wt_we = 1'b0;
  logic [CH_W-1:0] wt_ch = '0;
  logic [ADDR_W-1:0] wt_addr = '0;
  logic signed [WT_W-1:0] wt_data = '0;
  logic [NCH*WT_W-1:0] proj_i_flat, proj_q_flat;
  logic [NCH*PROJ_W-1:0] thr_flat;
  logic results_valid;
  logic [NCH-1:0] results;

  logic [31:0] ftw_a [NCH];
  logic signed [WT_W-1:0] pi_a [NCH];
  logic signed [WT_W-1:0] pq_a [NCH];
  logic signed [PROJ_W-1:0] thr_a [NCH];
  logic signed [SAMP_W-1:0] smp [MAX_LEN];
  logic signed [WT_W-1:0] wts [NCH][MAX_LEN];

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  logic [NCH-1:0] exp_res;

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ftw_flat[c*32 +: 32]         = ftw_a[c];
      proj_i_flat[c*WT_W +: WT_W]  = pi_a[c];
      proj_q_flat[c*WT_W +: WT_W]  = pq_a[c];
      thr_flat[c*PROJ_W +: PROJ_W] = thr_a[c];
    end
  end

  mux_readout_core #(.NCH(NCH), .SAMP_W(SAMP_W), .WT_W(WT_W), .ACC_W(ACC_W),
                     .MAX_LEN(MAX_LEN)) i_mux_readout_core (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_len(win_len),
    .sample_in(sample_in), .ftw_flat(ftw_flat), .wt_we(wt_we), .wt_ch(wt_ch),
    .wt_addr(wt_addr), .wt_data(wt_data), .proj_i_flat(proj_i_flat),
    .proj_q_flat(proj_q_flat), .thr_flat(thr_flat),
    .results_valid(results_valid), .results(results));

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint rnd(input real x);
    if (x >= 0.0) return longint'($rtoi(x + 0.5));
    return -longint'($rtoi(-x + 0.5));
  endfunction

  // Reference projection from the requirement text: octant oscillator, weighted sums.
  function automatic longint exp_proj(input int c, input int len);
    longint ai = 0;
    longint aq = 0;
    for (int k = 0; k < len; k++) begin
      logic [31:0] ph;
      real ang;
      longint lc, ls;
      ph  = ftw_a[c] * 32'(k);
      ang = real'(int'(ph[31:29])) * 3.14159265358979 / 4.0;
      lc  = rnd(64.0 * $cos(ang));
      ls  = rnd(64.0 * $sin(ang));
      ai += longint'(smp[k]) * lc * longint'(wts[c][k]);
      aq += longint'(smp[k]) * ls * longint'(wts[c][k]);
    end
    return longint'(pi_a[c]) * ai + longint'(pq_a[c]) * aq;
  endfunction

  function automatic logic signed [SAMP_W-1:0] rs();
    return SAMP_W'(int'($urandom_range(4095)) - 2048);
  endfunction

  task automatic rand_data(input int len);
    for (int k = 0; k < len; k++) smp[k] = rs();
    for (int c = 0; c < NCH; c++) begin
      pi_a[c] = rs();
      pq_a[c] = rs();
      for (int k = 0; k < len; k++) wts[c][k] = rs();
    end
  endtask

  task automatic load_weights(input int len);
    for (int c = 0; c < NCH; c++)
      for (int a = 0; a < len; a++) begin
        wt_we = 1'b1; wt_ch = CH_W'(c); wt_addr = ADDR_W'(a); wt_data = wts[c][a];
        @(negedge clk);
      end
    wt_we = 1'b0;
  endtask

  // Thresholds placed within +-2 of each projection (exercises the boundary).
  task automatic near_thresholds(input int len);
    for (int c = 0; c < NCH; c++)
      thr_a[c] = PROJ_W'(exp_proj(c, len) + longint'($urandom_range(4)) - 2);
  endtask

  // One window; poke >= 1 issues an extra request at that sample slot (poke == len: final cycle).
  task automatic run_win(input int len, input int poke, input string tag);
    for (int c = 0; c < NCH; c++) exp_res[c] = exp_proj(c, len) > longint'(thr_a[c]);
    win_len = LEN_W'(len);
    win_start = 1'b1;
    @(posedge clk); @(negedge clk);
    win_start = 1'b0;
    sample_in = smp[0];
    for (int k = 1; k < len; k++) begin
      @(posedge clk); @(negedge clk);
      sample_in = smp[k];
      win_start = (poke == k);
      if (poke == k) win_len = LEN_W'(1);
    end
    @(posedge clk); @(negedge clk);
    win_start = (poke == len);
    chk(results_valid == 1'b0, "R4 strobe early", results_valid, 0);
    @(posedge clk); @(negedge clk);
    win_start = 1'b0;
    chk(results_valid == 1'b1, "R4 strobe due", results_valid, 1);
    chk(results == exp_res, tag, results, exp_res);
    for (int i = 0; i < ((poke > 0) ? len + 3 : 2); i++) begin
      @(posedge clk); @(negedge clk);
      chk(results_valid == 1'b0, (poke > 0) ? "R6 extra strobe" : "R5 strobe width",
          results_valid, 0);
      chk(results == exp_res, "R5 results hold", results, exp_res);
    end
  endtask

  task automatic expect_silence(input int n, input string tag);
    logic [NCH-1:0] held;
    held = results;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      chk(results_valid == 1'b0, tag, results_valid, 0);
      chk(results == held, tag, results, held);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) begin
      ftw_a[c] = 32'd0; pi_a[c] = '0; pq_a[c] = '0; thr_a[c] = '0;
    end

    // Reset with start held high: R7, reset state R4.
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(results_valid == 1'b0 && results == '0, "R4 reset state", {results_valid, results}, 0);
    expect_silence(8, "R7 start held through reset");
    win_start = 1'b0;
    @(negedge clk);

    // R1: fixed frequency set covering every octant step size, DC-like and random data.
    ftw_a[0] = 32'd0;
    ftw_a[1] = 32'h2000_0000;
    ftw_a[2] = 32'h4000_0000;
    ftw_a[3] = 32'h1357_9BDF;
    for (int k = 0; k < 16; k++) smp[k] = SAMP_W'(1000);
    for (int c = 0; c < NCH; c++) begin
      pi_a[c] = WT_W'(3); pq_a[c] = WT_W'(-2);
      for (int k = 0; k < 16; k++) wts[c][k] = WT_W'(1);
    end
    load_weights(16);
    near_thresholds(16);
    run_win(16, -1, "R1 octant oscillator");
    rand_data(16);
    load_weights(16);
    near_thresholds(16);
    run_win(16, -1, "R1 octant oscillator random");

    // R3: exact-equality boundary (even channels equal, odd channels one below).
    rand_data(8);
    load_weights(8);
    for (int c = 0; c < NCH; c++) thr_a[c] = PROJ_W'(exp_proj(c, 8) - longint'(c % 2));
    run_win(8, -1, "R3 threshold boundary");

    // R7: illegal lengths ignored, controller still ready afterwards.
    win_len = '0; win_start = 1'b1; @(negedge clk); win_start = 1'b0;
    expect_silence(6, "R7 zero length ignored");
    win_len = LEN_W'(MAX_LEN + 1); win_start = 1'b1; @(negedge clk); win_start = 1'b0;
    expect_silence(70, "R7 oversize length ignored");

    // R4 length extremes.
    rand_data(1); load_weights(1); near_thresholds(1);
    run_win(1, -1, "R4 length one");
    rand_data(MAX_LEN); load_weights(MAX_LEN); near_thresholds(MAX_LEN);
    run_win(MAX_LEN, -1, "R4 full length");

    // R6: requests mid-window and in the final cycle.
    rand_data(12); load_weights(12); near_thresholds(12);
    run_win(12, 5, "R6 mid-window request");
    rand_data(12); load_weights(12); near_thresholds(12);
    run_win(12, 12, "R6 final-cycle request");

    // R8: rewrite one channel's single weight; other channels keep their memory.
    wts[2][3] = -wts[2][3] - WT_W'(1);
    wt_we = 1'b1; wt_ch = CH_W'(2); wt_addr = ADDR_W'(3); wt_data = wts[2][3];
    @(negedge clk);
    wt_we = 1'b0;
    near_thresholds(12);
    run_win(12, -1, "R8 single weight rewrite");

    // R2: constrained random windows with random frequencies.
    for (int n = 0; n < 20; n++) begin
      int len;
      len = int'($urandom_range(MAX_LEN - 1)) + 1;
      for (int c = 0; c < NCH; c++) ftw_a[c] = $urandom();
      rand_data(len); load_weights(len); near_thresholds(len);
      run_win(len, -1, "R2 random window");
    end

    summary();
    $finish;
  end
endmodule